// File: doc/BRIEF.md
# Stimulus Routing Matrix with Pattern Controllers

This block sends test stimulus to the eight input pins of a small device under test. Each pin has an eight-way selector. Six of its sources are clock taps of different rates, and the other two are a high rail and a low rail. The 24-bit select word that steers the selectors is registered, so a pin changes its source only on a clock edge. Each pin takes its own 3-bit field of the word.

The select word comes from one of three sequence controllers, one for each class of device:

- a two-input gate, which gets its four input conditions;
- a combinational function, which gets 4-bit input conditions counted from all zeros to all ones;
- a small memory, which gets a write phase and then a read phase, with address and data to match.

A command value taken from user switches is registered on every clock edge. Its low two bits choose the active controller. Its upper three bits give the select code for pin 7, which serves as a reference or clock pin. Any change to the command restarts the sequence. A step enable moves the active controller one condition forward.

Top module: `stim_route_matrix`

## Requirements
- R1: While reset is high, and after it is released with a class field of 0, sel_word is all ones: every pin uses code 7, so every pin_out bit equals tie_lo.
- R2: For each pin k, let c = sel_word[3k+2:3k]. Codes 0 to 5 route taps[c] to pin_out[k], where tap 0 is the fastest tap. Code 6 routes tie_hi and code 7 routes tie_lo. The pin follows its source combinationally.
- R3: cmd_in[1:0] is the class: 0 selects no controller, 1 the gate controller, 2 the combinational controller, 3 the memory controller. When the class is non-zero, cmd_in[4:2] becomes the code of pin 7. sel_word shows the command sampled at the most recent rising edge.
- R4: A class field of 0 sets every code to 7 after the next edge.
- R5: At an edge where cmd_in differs in any bit from the command held since the previous edge, the selected controller restarts at step 0 and does not advance.
- R6: When step_en is low and the command is unchanged, sel_word holds its value.
- R7: Gate class, 4 steps with wrap from 3 to 0. Pin 0 shows step bit 0 and pin 1 shows step bit 1. A bit of 1 gives code 6 and a bit of 0 gives code 7. Pins 2 to 6 use code 7.
- R8: Combinational class, 16 steps with wrap from 15 to 0. Pins 0 to 3 show step bits 0 to 3, with 1 giving code 6 and 0 giving code 7. Pins 4 to 6 use code 7.
- R9: Memory class, 8 steps with wrap. Steps 0 to 3 are writes: pin 0 (write strobe) is 6, pin 1 (read strobe) is 7, and pins 2 and 3 carry address bits 0 and 1, where the address is step[1:0]. Pins 4 to 6 carry data bits 0 to 2, where the data is (address+1) mod 8. Steps 4 to 7 are reads: pin 0 is 7, pin 1 is 6, pins 2 and 3 carry the address, and pins 4 to 6 are 7.
- R10: In memory class, the write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the active controller by one condition |
| cmd_in | input | 5 | Command: [1:0] class, [4:2] pin 7 code |
| taps | input | 6 | Clock taps, index 0 fastest |
| tie_hi | input | 1 | High rail source |
| tie_lo | input | 1 | Low rail source |
| pin_out | output | 8 | Drives for the pins of the device under test |
| sel_word | output | 24 | Registered select word, 3 bits per pin |

## Verification
The assertions assume that cmd_in and step_en are stable around the rising edge. They also assume that the taps and rails are ordinary two-state levels. Given that, the strobe, hold and restart properties follow from the command and enable alone. The bench changes these inputs only on falling edges. It mostly keeps one command for many cycles, so that long sequences and their wraps occur, and it switches to a random command only now and then. Tap and rail values are drawn at random, so that routing is checked with different values on every source.

// File: rtl/stim_route_pkg.sv
package stim_route_pkg;
    localparam int NUM_PINS = 8;
    localparam int CODE_W   = 3;
    localparam int NUM_TAPS = (1 << CODE_W) - 2;
    localparam int SEL_W    = NUM_PINS * CODE_W;
    localparam int CTL_W    = (NUM_PINS - 1) * CODE_W;
    localparam int CMD_W    = 2 + CODE_W;

    localparam logic [CODE_W-1:0] CODE_HI = CODE_W'(NUM_TAPS);
    localparam logic [CODE_W-1:0] CODE_LO = CODE_W'(NUM_TAPS + 1);

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_GATE = 2'd1,
        CLS_COMB = 2'd2,
        CLS_MEM  = 2'd3
    } dut_class_e;

    typedef struct packed {
        logic [CODE_W-1:0] ref_code;
        dut_class_e        cls;
    } cmd_t;

    function automatic logic [CODE_W-1:0] lvl_code(input logic b);
        return b ? CODE_HI : CODE_LO;
    endfunction

    function automatic int steps_of(input dut_class_e k);
        case (k)
            CLS_GATE: return 4;
            CLS_COMB: return 16;
            CLS_MEM:  return 8;
            default:  return 1;
        endcase
    endfunction
endpackage

// File: rtl/pin_selector.sv
module pin_selector
    import stim_route_pkg::*;
#(
    parameter int TAPS = NUM_TAPS,
    parameter int CW   = CODE_W
) (
    input  logic [TAPS-1:0] taps,
    input  logic            tie_hi,
    input  logic            tie_lo,
    input  logic [CW-1:0]   code,
    output logic            y
);
    localparam int SRC_N = TAPS + 2;
    logic [SRC_N-1:0] src;

    assign src = {tie_lo, tie_hi, taps};
    assign y   = src[code];
endmodule

// File: rtl/pattern_ctl.sv
module pattern_ctl
    import stim_route_pkg::*;
#(
    parameter dut_class_e KIND = CLS_GATE,
    parameter int OUT_W = CTL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    output logic [OUT_W-1:0] codes_nxt
);
    localparam int STEPS = steps_of(KIND);
    localparam int CNT_W = $clog2(STEPS);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (restart)
            cnt_nxt = '0;
        else if (advance)
            cnt_nxt = (cnt_q == CNT_W'(STEPS - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    generate
        if (KIND == CLS_GATE) begin : g_gate
            always_comb begin
                codes_nxt = {(OUT_W / CODE_W){CODE_LO}};
                codes_nxt[0*CODE_W +: CODE_W] = lvl_code(cnt_nxt[0]);
                codes_nxt[1*CODE_W +: CODE_W] = lvl_code(cnt_nxt[1]);
            end
        end else if (KIND == CLS_COMB) begin : g_comb
            always_comb begin
                codes_nxt = {(OUT_W / CODE_W){CODE_LO}};
                for (int k = 0; k < CNT_W; k++)
                    codes_nxt[k*CODE_W +: CODE_W] = lvl_code(cnt_nxt[k]);
            end
        end else begin : g_mem
            logic       wr_ph;
            logic [2:0] data;
            assign wr_ph = ~cnt_nxt[2];
            assign data  = {1'b0, cnt_nxt[1:0]} + 3'd1;
            always_comb begin
                codes_nxt = {(OUT_W / CODE_W){CODE_LO}};
                codes_nxt[0*CODE_W +: CODE_W] = lvl_code(wr_ph);
                codes_nxt[1*CODE_W +: CODE_W] = lvl_code(~wr_ph);
                codes_nxt[2*CODE_W +: CODE_W] = lvl_code(cnt_nxt[0]);
                codes_nxt[3*CODE_W +: CODE_W] = lvl_code(cnt_nxt[1]);
                if (wr_ph) begin
                    for (int k = 0; k < 3; k++)
                        codes_nxt[(4+k)*CODE_W +: CODE_W] = lvl_code(data[k]);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/stim_route_matrix.sv
module stim_route_matrix
    import stim_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic [CMD_W-1:0]    cmd_in,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                tie_hi,
    input  logic                tie_lo,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [SEL_W-1:0]    sel_word
);
    cmd_t             cmd_new, cmd_q;
    logic             restart;
    logic [3:0]       adv;
    logic [CTL_W-1:0] ctl_codes [4];
    logic [SEL_W-1:0] sel_nxt, sel_q;

    assign cmd_new = cmd_t'(cmd_in);
    assign restart = (cmd_in != CMD_W'(cmd_q));
    assign ctl_codes[0] = {(NUM_PINS - 1){CODE_LO}};
    assign adv[0] = 1'b0;

    for (genvar c = 1; c < 4; c++) begin : g_ctl
        assign adv[c] = step_en && !restart && (cmd_q.cls == dut_class_e'(c));
        pattern_ctl #(.KIND(dut_class_e'(c)), .OUT_W(CTL_W)) u_ctl (
            .clk       (clk),
            .rst       (rst),
            .restart   (restart),
            .advance   (adv[c]),
            .codes_nxt (ctl_codes[c])
        );
    end

    always_comb begin
        if (cmd_new.cls == CLS_NONE)
            sel_nxt = {NUM_PINS{CODE_LO}};
        else
            sel_nxt = {cmd_new.ref_code, ctl_codes[cmd_new.cls]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            sel_q <= {NUM_PINS{CODE_LO}};
        end else begin
            cmd_q <= cmd_new;
            sel_q <= sel_nxt;
        end
    end

    assign sel_word = sel_q;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        pin_selector #(.TAPS(NUM_TAPS), .CW(CODE_W)) u_sel (
            .taps   (taps),
            .tie_hi (tie_hi),
            .tie_lo (tie_lo),
            .code   (sel_q[k*CODE_W +: CODE_W]),
            .y      (pin_out[k])
        );
    end
endmodule

// File: rtl/stim_route_matrix_chk.sv
module stim_route_matrix_chk
    import stim_route_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                step_en,
    input logic [CMD_W-1:0]    cmd_in,
    input logic [NUM_TAPS-1:0] taps,
    input logic                tie_hi,
    input logic                tie_lo,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [SEL_W-1:0]    sel_word
);
    logic [CMD_W-1:0] last_cmd;

    always_ff @(posedge clk) begin
        if (rst) last_cmd <= '0;
        else     last_cmd <= cmd_in;
    end

    p_hi_route_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_word[2:0] == CODE_HI) |-> (pin_out[0] == tie_hi));

    p_lo_route_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_word[SEL_W-1 -: CODE_W] == CODE_LO) |-> (pin_out[NUM_PINS-1] == tie_lo));

    p_ref_pin_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_in[1:0] != 2'd0) |=> (sel_word[SEL_W-1 -: CODE_W] == $past(cmd_in[CMD_W-1:2])));

    p_none_low_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_in[1:0] == 2'd0) |=> (sel_word == {NUM_PINS{CODE_LO}}));

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        ((cmd_in != last_cmd) && (cmd_in[1:0] != 2'd0)) |=> (sel_word[5:3] == CODE_LO));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ((cmd_in == last_cmd) && !step_en) |=> $stable(sel_word));

    p_gate_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (last_cmd[1:0] == 2'd1) |-> (sel_word[CTL_W-1:2*CODE_W] == {(NUM_PINS-3){CODE_LO}}));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        (last_cmd[1:0] == 2'd3) |-> !((sel_word[2:0] == CODE_HI) && (sel_word[5:3] == CODE_HI)));
endmodule

bind stim_route_matrix stim_route_matrix_chk u_chk (.*);

// File: tb/stim_route_matrix_test.sv
module stim_route_matrix_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [4:0]  cmd_in = '0;
    logic [5:0]  taps = '0;
    logic        tie_hi = 1'b1;
    logic        tie_lo = 1'b0;
    logic [7:0]  pin_out;
    logic [23:0] sel_word;

    int n_chk = 0;
    int n_bad = 0;
    int m_step = 0;
    logic [4:0] m_cmd = '0;
    bit done = 0;

    always #5 clk = ~clk;

    stim_route_matrix uut (
        .clk(clk), .rst(rst), .step_en(step_en), .cmd_in(cmd_in),
        .taps(taps), .tie_hi(tie_hi), .tie_lo(tie_lo),
        .pin_out(pin_out), .sel_word(sel_word)
    );

    function automatic logic [2:0] lv(input logic b);
        return b ? 3'd6 : 3'd7;
    endfunction

    function automatic int seq_len(input logic [1:0] c);
        case (c)
            2'd1: return 4;
            2'd2: return 16;
            2'd3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [23:0] exp_sel(input logic [4:0] c, input int s);
        logic [23:0] w = '1;
        logic [3:0]  b = 4'(s);
        logic [2:0]  d;
        if (c[1:0] == 2'd0) return w;
        w[23:21] = c[4:2];
        case (c[1:0])
            2'd1: begin
                w[2:0] = lv(b[0]); w[5:3] = lv(b[1]);
            end
            2'd2: begin
                for (int k = 0; k < 4; k++) w[k*3 +: 3] = lv(b[k]);
            end
            default: begin
                w[2:0] = lv(!b[2]); w[5:3] = lv(b[2]);
                w[8:6] = lv(b[0]);  w[11:9] = lv(b[1]);
                d = {1'b0, b[1:0]} + 3'd1;
                if (!b[2]) for (int k = 0; k < 3; k++) w[(4+k)*3 +: 3] = lv(d[k]);
            end
        endcase
        return w;
    endfunction

    function automatic logic [7:0] exp_pins(input logic [23:0] w);
        logic [7:0] p;
        logic [7:0] src = {tie_lo, tie_hi, taps};
        for (int k = 0; k < 8; k++) p[k] = src[w[k*3 +: 3]];
        return p;
    endfunction

    task automatic check(input string req);
        logic [23:0] ew = exp_sel(m_cmd, m_step);
        logic [7:0]  ep = exp_pins(ew);
        n_chk++;
        if (sel_word !== ew) begin
            n_bad++;
            $display("FAIL %s sel_word actual=%h expected=%h", req, sel_word, ew);
        end
        n_chk++;
        if (pin_out !== ep) begin
            n_bad++;
            $display("FAIL %s pin_out actual=%b expected=%b", req, pin_out, ep);
        end
    endtask

    // one clock: model update at the edge, check at the following falling edge
    task automatic tick(input string req);
        @(posedge clk);
        if (rst) begin
            m_cmd = '0; m_step = 0;
        end else begin
            if (cmd_in != m_cmd) m_step = 0;
            else if (step_en && cmd_in[1:0] != 2'd0) m_step = (m_step + 1) % seq_len(cmd_in[1:0]);
            m_cmd = cmd_in;
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic walk(input logic [4:0] c, input int n, input string req);
        cmd_in = c; step_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            taps = 6'($urandom);
            tick(req);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        tick("R1");
        rst = 1'b0;
        tick("R1");
        tick("R4");
        // routing with distinct rails and tap patterns
        taps = 6'b101010; tick("R2");
        tie_hi = 1'b0; tie_lo = 1'b1; tick("R2");
        tie_hi = 1'b1; tie_lo = 1'b0;
        // gate class, pin 7 on fastest tap, wrap past 3
        walk(5'b000_01, 6, "R7");
        // R5: only the reference code changes, sequence restarts
        cmd_in = 5'b101_01; tick("R5");
        // R6: step enable low holds state
        step_en = 1'b0; tick("R6"); tick("R6");
        // combinational class, full sweep plus wrap
        walk(5'b011_10, 18, "R8");
        // memory class, write then read, wrap; R10 strobes
        walk(5'b110_11, 10, "R9");
        // R3: pin 7 code from each value while taps vary
        for (int r = 0; r < 8; r++) begin
            cmd_in = {3'(r), 2'd1}; taps = 6'($urandom); tick("R3");
        end
        // R4: no class selected
        walk(5'b010_00, 3, "R4");
        // random phase
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 16) == 0) cmd_in = 5'($urandom);
            step_en = 1'($urandom);
            taps = 6'($urandom);
            tie_hi = (($urandom % 8) == 0) ? 1'b0 : 1'b1;
            tie_lo = (($urandom % 8) == 0) ? 1'b1 : 1'b0;
            tick("R2");
        end
        // reset in mid sequence
        cmd_in = 5'b000_00; rst = 1'b1; tick("R1");
        rst = 1'b0; tick("R1");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule